// File: doc/BRIEF.md
# SDRAM Presence-Detect Image Generator

This block builds the 256-byte presence-detect table that describes a memory module. The table is derived from two inputs: a memory family (SDR, DDR or DDR2) and a module capacity in megabytes. A single-cycle `start` pulse captures both inputs. An iterative splitter then breaks the capacity into a bank count and a per-bank size. After that, the block streams the full table, one byte per clock, through a RAM-style write port (`wr_en`, `wr_addr`, `wr_data`) into whatever storage the chip later serves over its serial bus.

The controller is a six-state machine:
- IDLE waits for `start`.
- LAUNCH latches the inputs and clears the checksum.
- WAIT runs the splitter until it reports.
- EMIT writes addresses 0 to 255.
- FINISH raises `done` for one cycle.
- FAULT raises `err` for one cycle.

The controller moves along these transitions: IDLE→LAUNCH on `start`, LAUNCH→WAIT, WAIT→EMIT when the split is legal, WAIT→FAULT when it is not, EMIT→FINISH after byte 255, and FINISH→IDLE and FAULT→IDLE.

The splitter has its own four states:
- SP_IDLE loads the capacity and validates it.
- SP_HALVE repeatedly halves the bank size while doubling the bank count.
- SP_BAL applies the one-time two-bank split.
- SP_DONE reports the result.

Top module: `spd_image_gen`

## Requirements
- R1: The per-family legal range of log2(capacity in MB) has a lower bound of 2 for SDR, 5 for DDR and 7 for DDR2. A capacity whose log2 is below that bound pulses `err` for one cycle, and the block makes no write and raises no `done`.
- R2: In each of these cases the block pulses `err` for one cycle and writes nothing: a capacity of zero, a capacity that is not a power of two, or a `mem_type` value of 3. The `mem_type` encoding is 0 for SDR, 1 for DDR and 2 for DDR2.
- R3: Splitting starts from one bank. While log2 of the bank size exceeds the family upper bound (9 for SDR, 12 for DDR, 14 for DDR2) and the count is below 8, the bank size halves and the count doubles.
- R4: If that step leaves one bank whose log2 size is above the family lower bound, the module is reported as two banks of half size.
- R5: Byte 31 carries the density code, derived from raw = 2^(log2 bank size − 2):
  - DDR2: (raw & 0xE0) | ((raw >> 8) & 0x1F)
  - DDR: (raw & 0xF8) | ((raw >> 8) & 0x07)
  - SDR: raw & 0xFF
- R6: Byte 5 is the bank count minus one for DDR2 and the bank count for SDR and DDR.
- R7: The header bytes are fixed:
  - byte 0 = 128
  - byte 1 = 8
  - byte 3 = 13
  - byte 4 = 10
  - byte 6 = 64
  - byte 2 is the family code: 4 for SDR, 7 for DDR, 8 for DDR2.
- R8: Bytes 15 and 19 are 0 for DDR2 and 1 for the other families. Bytes 27, 28, 29 and 30 are 20, 15, 20 and 45.
- R9: Byte 63 is the modulo-256 sum of bytes 0 to 62. Every byte not named in R5 to R8 is zero.
- R10: A legal request writes exactly 256 bytes in consecutive cycles, at addresses 0, 1, …, 255 in that order.
- R11: `done` is high for exactly one cycle, in the cycle after byte 255 is written. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin generation (ignored while busy) |
| mem_type | input | 2 | Memory family: 0 SDR, 1 DDR, 2 DDR2, 3 illegal |
| size_mb | input | SIZE_W | Module capacity in megabytes |
| busy | output | 1 | A request is in progress |
| wr_en | output | 1 | Image byte write strobe |
| wr_addr | output | 8 | Image byte address |
| wr_data | output | 8 | Image byte value |
| done | output | 1 | One-cycle pulse after the last byte |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
Every family is driven with every power-of-two capacity that the size port can express. This single sweep covers three regions:
- capacities below the legal floor, which separate rejection from emission;
- in-range capacities, which separate the one-bank case from the two-bank split;
- oversized capacities, which drive the doubling loop to the eight-bank cap and, past it, into density codes whose upper raw bits must fold into the low field of byte 31.

Each of these sweeps compares the full table byte by byte. Zero, several non-power-of-two capacities and the reserved family code check that nothing is written on rejection. A start pulse injected mid-stream with a different family shows that a running image is not disturbed.

// File: rtl/spd_gen_pkg.sv
package spd_gen_pkg;

    typedef enum logic [1:0] {
        KIND_SDR  = 2'd0,
        KIND_DDR  = 2'd1,
        KIND_DDR2 = 2'd2,
        KIND_BAD  = 2'd3
    } mem_kind_e;

    localparam int BANK_CAP    = 8;
    localparam int IMAGE_BYTES = 256;
    localparam int CSUM_ADDR   = 63;

    function automatic int floor_log2(input mem_kind_e k);
        unique case (k)
            KIND_SDR:  return 2;
            KIND_DDR:  return 5;
            KIND_DDR2: return 7;
            default:   return 0;
        endcase
    endfunction

    function automatic int ceil_log2(input mem_kind_e k);
        unique case (k)
            KIND_SDR:  return 9;
            KIND_DDR:  return 12;
            KIND_DDR2: return 14;
            default:   return 0;
        endcase
    endfunction

    function automatic logic [7:0] family_code(input mem_kind_e k);
        unique case (k)
            KIND_SDR:  return 8'd4;
            KIND_DDR:  return 8'd7;
            KIND_DDR2: return 8'd8;
            default:   return 8'd0;
        endcase
    endfunction

    function automatic logic [7:0] pack_density(input mem_kind_e k, input int lg);
        logic [31:0] raw;
        logic [7:0]  lo;
        logic [7:0]  hi;
        raw = 32'd1 << (lg - 2);
        lo  = raw[7:0];
        hi  = raw[15:8];
        unique case (k)
            KIND_DDR2: return (lo & 8'hE0) | (hi & 8'h1F);
            KIND_DDR:  return (lo & 8'hF8) | (hi & 8'h07);
            default:   return lo;
        endcase
    endfunction

endpackage

// File: rtl/spd_size_split.sv
module spd_size_split
    import spd_gen_pkg::*;
#(
    parameter int SIZE_W = 20,
    localparam int LG_W  = $clog2(SIZE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  mem_kind_e         kind,
    input  logic [SIZE_W-1:0] size_mb,
    output logic              ready,
    output logic              bad,
    output logic [LG_W-1:0]   lg_out,
    output logic [3:0]        banks_out
);

    typedef enum logic [1:0] {SP_IDLE, SP_HALVE, SP_BAL, SP_DONE} sp_state_e;

    sp_state_e       st_q, st_d;
    logic [LG_W-1:0] lg_q, lg_d;
    logic [3:0]      banks_q, banks_d;
    logic            bad_q, bad_d;

    logic [LG_W-1:0] lg_c;
    logic            pow2_c;

    always_comb begin
        lg_c = '0;
        for (int i = 0; i < SIZE_W; i++) begin
            if (size_mb[i]) lg_c = LG_W'(i);
        end
        pow2_c = (size_mb != '0) && ((size_mb & (size_mb - 1'b1)) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= SP_IDLE;
            lg_q    <= '0;
            banks_q <= 4'd1;
            bad_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            lg_q    <= lg_d;
            banks_q <= banks_d;
            bad_q   <= bad_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        lg_d    = lg_q;
        banks_d = banks_q;
        bad_d   = bad_q;
        ready   = 1'b0;
        unique case (st_q)
            SP_IDLE: begin
                if (go) begin
                    lg_d    = lg_c;
                    banks_d = 4'd1;
                    bad_d   = !pow2_c || (kind == KIND_BAD) ||
                              (int'(lg_c) < floor_log2(kind));
                    st_d    = bad_d ? SP_DONE : SP_HALVE;
                end
            end
            SP_HALVE: begin
                if ((int'(lg_q) > ceil_log2(kind)) && (int'(banks_q) < BANK_CAP)) begin
                    lg_d    = lg_q - 1'b1;
                    banks_d = banks_q << 1;
                end else begin
                    st_d = SP_BAL;
                end
            end
            SP_BAL: begin
                if ((banks_q == 4'd1) && (int'(lg_q) > floor_log2(kind))) begin
                    lg_d    = lg_q - 1'b1;
                    banks_d = 4'd2;
                end
                st_d = SP_DONE;
            end
            SP_DONE: begin
                ready = 1'b1;
                st_d  = SP_IDLE;
            end
            default: st_d = SP_IDLE;
        endcase
    end

    assign bad       = bad_q;
    assign lg_out    = lg_q;
    assign banks_out = banks_q;

    AST_BANKS_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(banks_q) && (int'(banks_q) <= BANK_CAP)); // R3
    AST_HALVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SP_HALVE && banks_d != banks_q) |=>
        (lg_q == $past(lg_q) - 1'b1) && (banks_q == ($past(banks_q) << 1))); // R3
    AST_BAL_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SP_BAL && banks_q == 4'd1 && int'(lg_q) > floor_log2(kind)) |=>
        (banks_q == 4'd2)); // R4

endmodule

// File: rtl/spd_field_map.sv
module spd_field_map
    import spd_gen_pkg::*;
(
    input  logic [7:0] addr,
    input  mem_kind_e  kind,
    input  logic [3:0] banks,
    input  logic [7:0] density,
    output logic [7:0] value
);

    logic is_ddr2;
    assign is_ddr2 = (kind == KIND_DDR2);

    always_comb begin
        unique case (addr)
            8'd0:    value = 8'd128;
            8'd1:    value = 8'd8;
            8'd2:    value = family_code(kind);
            8'd3:    value = 8'd13;
            8'd4:    value = 8'd10;
            8'd5:    value = is_ddr2 ? {4'd0, banks - 4'd1} : {4'd0, banks};
            8'd6:    value = 8'd64;
            8'd15:   value = is_ddr2 ? 8'd0 : 8'd1;
            8'd19:   value = is_ddr2 ? 8'd0 : 8'd1;
            8'd27:   value = 8'd20;
            8'd28:   value = 8'd15;
            8'd29:   value = 8'd20;
            8'd30:   value = 8'd45;
            8'd31:   value = density;
            default: value = 8'd0;
        endcase
    end

endmodule

// File: rtl/spd_csum_acc.sv
module spd_csum_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       add_en,
    input  logic [7:0] din,
    output logic [7:0] sum
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= 8'd0;
        end else if (clear) begin
            sum <= 8'd0;
        end else if (add_en) begin
            sum <= sum + din;
        end
    end

    AST_CSUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !add_en) |=> $stable(sum)); // R9
    AST_CSUM_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && add_en) |=> (sum == $past(sum) + $past(din))); // R9

endmodule

// File: rtl/spd_image_gen.sv
module spd_image_gen
    import spd_gen_pkg::*;
#(
    parameter int SIZE_W = 20,
    localparam int LG_W  = $clog2(SIZE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mem_type,
    input  logic [SIZE_W-1:0] size_mb,
    output logic              busy,
    output logic              wr_en,
    output logic [7:0]        wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              err
);

    typedef enum logic [2:0] {
        ST_IDLE, ST_LAUNCH, ST_WAIT, ST_EMIT, ST_FINISH, ST_FAULT
    } gen_state_e;

    gen_state_e        st_q, st_d;
    mem_kind_e         kind_q;
    logic [SIZE_W-1:0] size_q;
    logic [7:0]        addr_q;
    logic [7:0]        dens_q;
    logic [3:0]        banks_q;

    logic              sp_ready, sp_bad;
    logic [LG_W-1:0]   sp_lg;
    logic [3:0]        sp_banks;
    logic [7:0]        map_byte;
    logic [7:0]        csum;
    logic              csum_clear, csum_add;

    spd_size_split #(.SIZE_W(SIZE_W)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (st_q == ST_LAUNCH),
        .kind      (kind_q),
        .size_mb   (size_q),
        .ready     (sp_ready),
        .bad       (sp_bad),
        .lg_out    (sp_lg),
        .banks_out (sp_banks)
    );

    spd_field_map u_map (
        .addr    (addr_q),
        .kind    (kind_q),
        .banks   (banks_q),
        .density (dens_q),
        .value   (map_byte)
    );

    spd_csum_acc u_csum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (csum_clear),
        .add_en (csum_add),
        .din    (map_byte),
        .sum    (csum)
    );

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            kind_q  <= KIND_SDR;
            size_q  <= '0;
            addr_q  <= 8'd0;
            dens_q  <= 8'd0;
            banks_q <= 4'd1;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start) begin
                kind_q <= mem_kind_e'(mem_type);
                size_q <= size_mb;
            end
            if (st_q == ST_WAIT && sp_ready) begin
                banks_q <= sp_banks;
                dens_q  <= pack_density(kind_q, int'(sp_lg));
                addr_q  <= 8'd0;
            end else if (st_q == ST_EMIT) begin
                addr_q <= addr_q + 8'd1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        st_d       = st_q;
        busy       = 1'b1;
        wr_en      = 1'b0;
        done       = 1'b0;
        err        = 1'b0;
        csum_clear = 1'b0;
        csum_add   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (start) st_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                csum_clear = 1'b1;
                st_d       = ST_WAIT;
            end
            ST_WAIT: begin
                if (sp_ready) st_d = sp_bad ? ST_FAULT : ST_EMIT;
            end
            ST_EMIT: begin
                wr_en    = 1'b1;
                csum_add = (int'(addr_q) < CSUM_ADDR);
                if (addr_q == 8'(IMAGE_BYTES - 1)) st_d = ST_FINISH;
            end
            ST_FINISH: begin
                done = 1'b1;
                st_d = ST_IDLE;
            end
            ST_FAULT: begin
                err  = 1'b1;
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign wr_addr = addr_q;
    assign wr_data = (int'(addr_q) == CSUM_ADDR) ? csum : map_byte;

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 8'd0) |-> ($past(wr_en) && wr_addr == $past(wr_addr) + 8'd1)); // R10
    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> (wr_addr == 8'd0)); // R10
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(wr_en) && $past(wr_addr) == 8'hFF)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!$past(wr_en) && !wr_en)); // R2
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R1

endmodule

// File: tb/spd_image_gen_test.sv
module spd_image_gen_test;

    localparam int SIZE_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        mem_type = 2'd0;
    logic [SIZE_W-1:0] size_mb = '0;
    logic              busy, wr_en, done, err;
    logic [7:0]        wr_addr, wr_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_img [256];
    logic [7:0] got_img [256];

    always #2 clk = ~clk;

    spd_image_gen #(.SIZE_W(SIZE_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_type(mem_type),
        .size_mb(size_mb), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string byte_req(input int a);
        if (a == 63) return "R9 checksum";
        if (a == 31) return "R5 density";
        if (a == 5) return "R6 banks";
        if (a <= 6) return "R7 header";
        if (a == 15 || a == 19 || (a >= 27 && a <= 30)) return "R8 timing";
        return "R9 zero";
    endfunction

    // model from the requirements; returns 1 when the request is legal
    function automatic bit build_expected(input int t, input longint sz);
        int lo, hi, lg, nb, code, raw, dens, s;
        if (t == 3 || sz <= 0 || (sz & (sz - 1)) != 0) return 0;
        lo = (t == 0) ? 2 : (t == 1) ? 5 : 7;
        hi = (t == 0) ? 9 : (t == 1) ? 12 : 14;
        code = (t == 0) ? 4 : (t == 1) ? 7 : 8;
        lg = 0;
        while ((64'd1 << lg) < sz) lg++;
        if (lg < lo) return 0;
        nb = 1;
        while (lg > hi && nb < 8) begin lg--; nb = nb * 2; end
        if (nb == 1 && lg > lo) begin lg--; nb = 2; end
        raw = 1 << (lg - 2);
        if (t == 2) dens = (raw & 'hE0) | ((raw >> 8) & 'h1F);
        else if (t == 1) dens = (raw & 'hF8) | ((raw >> 8) & 'h07);
        else dens = raw & 'hFF;
        for (int i = 0; i < 256; i++) exp_img[i] = 8'd0;
        exp_img[0] = 8'd128; exp_img[1] = 8'd8; exp_img[2] = 8'(code);
        exp_img[3] = 8'd13; exp_img[4] = 8'd10;
        exp_img[5] = 8'((t == 2) ? nb - 1 : nb);
        exp_img[6] = 8'd64;
        exp_img[15] = (t == 2) ? 8'd0 : 8'd1;
        exp_img[19] = (t == 2) ? 8'd0 : 8'd1;
        exp_img[27] = 8'd20; exp_img[28] = 8'd15; exp_img[29] = 8'd20; exp_img[30] = 8'd45;
        exp_img[31] = 8'(dens);
        s = 0;
        for (int i = 0; i < 63; i++) s += exp_img[i];
        exp_img[63] = 8'(s);
        return 1;
    endfunction

    task automatic run_case(input int t, input longint sz, input bit poke);
        bit legal;
        int nwr, last_wr_cyc, done_cyc, nerr, ndone, cyc;
        bit order_ok;
        legal = build_expected(t, sz);
        @(negedge clk);
        mem_type = 2'(t); size_mb = SIZE_W'(sz); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nwr = 0; nerr = 0; ndone = 0; order_ok = 1; last_wr_cyc = -1; done_cyc = -1;
        for (cyc = 0; cyc < 400; cyc++) begin
            @(negedge clk);
            if (poke && cyc == 100) begin
                mem_type = 2'((t + 1) % 3); size_mb = SIZE_W'(64); start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (wr_en) begin
                if (int'(wr_addr) != nwr) order_ok = 0;
                got_img[wr_addr] = wr_data;
                nwr++; last_wr_cyc = cyc;
            end
            if (err) nerr++;
            if (done) begin ndone++; done_cyc = cyc; end
            if (!busy && cyc > 2 && !start) break;
        end
        start = 1'b0;
        if (legal) begin
            check(nwr == 256, "R10 write count", nwr, 256);
            check(order_ok, "R10 ascending order", order_ok, 1);
            check(ndone == 1 && done_cyc == last_wr_cyc + 1, "R11 done after byte 255",
                  done_cyc, last_wr_cyc + 1);
            check(nerr == 0, "R1 no err on legal", nerr, 0);
            for (int i = 0; i < 256; i++)
                check(got_img[i] == exp_img[i], byte_req(i), got_img[i], exp_img[i]);
        end else begin
            check(nerr == 1, "R1 R2 err pulse", nerr, 1);
            check(nwr == 0, "R2 no writes on reject", nwr, 0);
            check(ndone == 0, "R1 no done on reject", ndone, 0);
        end
        if (poke) check(!busy, "R11 mid-run start ignored", busy, 0);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !wr_en && !done && !err, "R11 reset state", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !wr_en && !done && !err, "R11 idle after reset", wr_en, 0);
        // R3 R4 R5: every family, every power-of-two capacity
        for (int t = 0; t < 3; t++)
            for (int k = 0; k < SIZE_W; k++)
                run_case(t, longint'(1) << k, 1'b0);
        // R2 rejections
        run_case(0, 0, 1'b0);
        run_case(1, 3, 1'b0);
        run_case(2, 768, 1'b0);
        run_case(0, 1000, 1'b0);
        run_case(3, 64, 1'b0);
        // R11 start while busy
        run_case(2, 4096, 1'b1);
        run_case(1, 32768, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule